// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block acts as a small serial EEPROM on a two-wire bus. A fast system clock samples the SCL line and the incoming SDA level. The block drives an outgoing SDA level that the surrounding logic combines onto the bus. It holds a byte array of up to 8 KB.

The block does not decode bytes as they arrive. Instead it counts SCL pulses within each transaction, and the count alone decides whether a bit is part of an address, part of the data or an acknowledge slot. A static mode input picks one of three addressing schemes:

- a legacy scheme whose first byte carries a 7-bit word address;
- a scheme with a device byte followed by one word-address byte;
- a scheme with a device byte followed by two word-address bytes.

Top module: `eep_slave`

## Requirements
- R1: A fall of SDA while SCL stays high (judged between two consecutive samples) starts a transaction and resets the pulse count to 0; each later SCL rise adds one, and data bits are taken on SCL falls, MSB first.
- R2: A rise of SDA while SCL stays high ends the transaction; afterwards SCL pulses produce no acknowledge.
- R3: When SCL and SDA both change in the same sample, this counts as an SCL edge only and is never a start or a stop.
- R4: While no transaction is open, sdaOut equals sdaIn.
- R5: The acknowledge pulses drive sdaOut to 0. These are pulse 9 in every mode, plus pulses 18 and 27 in the device-byte modes. Write bytes in the device-byte modes are acknowledged at 18 (one-byte mode, which rewinds 27 to 18) or at 27 (two-byte mode, which rewinds 36 to 27).
- R6: mode=0 (legacy) handles the first byte as follows. Bits 7:1 of the first byte form the word address and bit 0 selects read (1) or write (0). Data occupies pulses 10 to 17, and pulse 18 rewinds to 9.
- R7: In legacy mode, each written byte advances only address bits 1:0, so writes wrap within an aligned 4-byte page.
- R8: In legacy mode, a read advances the address by one at each rewind, wrapping from 0x7F to 0x00.
- R9: mode=1 uses a device byte followed by one address byte. The address byte forms word-address bits 7:0, and device-byte bits 3:1 form word-address bits 10:8.
- R10: mode=2 uses a device byte followed by two address bytes. The first address byte is sent first, and the two bytes together form a 13-bit word address (bits 4:0 of the first byte, then all 8 bits of the second).
- R11: In modes 1 and 2, each written byte advances only address bits 3:0, so writes wrap within an aligned 16-byte page.
- R12: In modes 1 and 2, device-byte bit 0 set to 1 selects read. In a read, pulse 18 rewinds to 9 and advances the full 13-bit address by one, crossing page and block boundaries.
- R13: During read pulses 10 to 17, sdaOut carries bit (17 - pulse) of the addressed byte, and every byte read equals the byte last committed there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus levels |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Addressing scheme: 0 legacy, 1 one address byte, 2 two address bytes (static) |
| sclIn | input | 1 | Sampled SCL level |
| sdaIn | input | 1 | Sampled incoming SDA level |
| sdaOut | output | 1 | Outgoing SDA level (acknowledge, read data or open-bus echo) |

## Verification
The bench builds the block with ADDR_BITS=11, which gives a 2 KB array. This size is enough for the device-byte bits 3:1 of the one-byte mode to select separate blocks. It also lets a sequential read in that mode cross from 0x3FF into 0x400, and lets the two-byte mode use address 0x7FE and the page wrap to 0x7F0. Legacy tests stay within the first 128 bytes to exercise the 4-byte page wrap and the wrap from 0x7F to 0x00.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int WORD_ADDR_W = 13;
  localparam int CYC_W       = 6;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_ONE    = 2'd1,
    MODE_TWO    = 2'd2
  } eepMode_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic       shiftSlave;
    logic       loadLegacyAddr;
    logic       shiftAddr;
    logic       finishShortAddr;
    logic       shiftData;
    logic       commitData;
    logic       advanceRead;
    logic       bitIn;
    logic       driveAck;
    logic       driveData;
    logic [2:0] bitSel;
  } eepStrobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          mode,
  input  logic                sclIn,
  input  logic                sdaIn,
  output eepStrobe_t          strobe,
  output logic                started,
  output logic [CYC_W-1:0]    bitCyc
);

  logic prevScl, prevSda;
  logic readMode;

  // previous levels follow the inputs every clock, reset or not
  always_ff @(posedge clk) begin
    prevScl <= sclIn;
    prevSda <= sdaIn;
  end

  logic sclHeld, startDet, stopDet, sclRise, sclFall;
  assign sclHeld  = prevScl & sclIn;
  assign startDet = sclHeld & prevSda & ~sdaIn;
  assign stopDet  = sclHeld & ~prevSda & sdaIn;
  assign sclRise  = ~prevScl & sclIn;
  assign sclFall  = prevScl & ~sclIn;

  logic isLegacy, isTwo;
  assign isLegacy = (mode == MODE_LEGACY);
  assign isTwo    = (mode == MODE_TWO);

  logic [CYC_W-1:0] nextCyc, riseTarget;
  logic             riseAdvance;
  assign nextCyc = bitCyc + 1'b1;

  always_comb begin
    riseTarget  = nextCyc;
    riseAdvance = 1'b0;
    if (isLegacy) begin
      if (nextCyc == 6'd18) begin
        riseTarget  = 6'd9;
        riseAdvance = readMode;
      end
    end else if (readMode) begin
      if (nextCyc == 6'd18) begin
        riseTarget  = 6'd9;
        riseAdvance = 1'b1;
      end
    end else if (isTwo) begin
      if (nextCyc == 6'd36) riseTarget = 6'd27;
    end else begin
      if (nextCyc == 6'd27) riseTarget = 6'd18;
    end
  end

  logic inSlave, inFirst, inSecond, inThird, writeMode, fallAct, lastSlaveBit;
  assign inSlave   = (bitCyc >= 6'd1)  && (bitCyc <= 6'd8);
  assign inFirst   = (bitCyc >= 6'd10) && (bitCyc <= 6'd17);
  assign inSecond  = (bitCyc >= 6'd19) && (bitCyc <= 6'd26);
  assign inThird   = (bitCyc >= 6'd28) && (bitCyc <= 6'd35);
  assign writeMode = ~readMode;
  assign fallAct   = started & sclFall;
  assign lastSlaveBit = fallAct & (bitCyc == 6'd8);

  always_comb begin
    strobe                 = '0;
    strobe.bitIn           = sdaIn;
    strobe.shiftSlave      = fallAct & inSlave;
    strobe.loadLegacyAddr  = lastSlaveBit & isLegacy;
    strobe.advanceRead     = started & sclRise & riseAdvance;
    if (fallAct && writeMode) begin
      if (isLegacy) begin
        strobe.shiftData  = inFirst;
        strobe.commitData = (bitCyc == 6'd17);
      end else if (isTwo) begin
        strobe.shiftAddr  = inFirst | inSecond;
        strobe.shiftData  = inThird;
        strobe.commitData = (bitCyc == 6'd35);
      end else begin
        strobe.shiftAddr       = inFirst;
        strobe.finishShortAddr = (bitCyc == 6'd17);
        strobe.shiftData       = inSecond;
        strobe.commitData      = (bitCyc == 6'd26);
      end
    end
    strobe.driveAck  = started & ((bitCyc == 6'd9) | (bitCyc == 6'd18) | (bitCyc == 6'd27));
    strobe.driveData = started & readMode & inFirst;
    strobe.bitSel    = 3'd1 - bitCyc[2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      bitCyc   <= '0;
      readMode <= 1'b0;
    end else if (startDet) begin
      started <= 1'b1;
      bitCyc  <= '0;
    end else if (stopDet) begin
      started <= 1'b0;
    end else if (started && sclRise) begin
      bitCyc <= riseTarget;
    end else if (lastSlaveBit) begin
      readMode <= sdaIn;
    end
  end

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  eepStrobe_t strobe,
  output logic       sdaOut
);

  localparam int MEM_DEPTH = 1 << ADDR_BITS;

  logic                   isLegacy;
  logic [6:0]             slaveSh;
  logic [6:0]             dataSh;
  logic [WORD_ADDR_W-1:0] addrReg;
  logic [7:0]             newByte;
  logic [7:0]             mem [MEM_DEPTH];
  logic [ADDR_BITS-1:0]   memIdx;
  logic [7:0]             rdByte;

  assign isLegacy = (mode == MODE_LEGACY);
  assign newByte  = {dataSh, strobe.bitIn};
  assign memIdx   = addrReg[ADDR_BITS-1:0];
  assign rdByte   = mem[memIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveSh <= '0;
      dataSh  <= '0;
      addrReg <= '0;
    end else begin
      if (strobe.shiftSlave) slaveSh <= {slaveSh[5:0], strobe.bitIn};
      if (strobe.shiftData)  dataSh  <= {dataSh[5:0], strobe.bitIn};
      if (strobe.loadLegacyAddr)
        addrReg <= {6'd0, slaveSh};
      else if (strobe.finishShortAddr)
        addrReg <= {2'd0, slaveSh[3:1], addrReg[6:0], strobe.bitIn};
      else if (strobe.shiftAddr)
        addrReg <= {addrReg[WORD_ADDR_W-2:0], strobe.bitIn};
      else if (strobe.commitData) begin
        if (isLegacy) addrReg <= {addrReg[WORD_ADDR_W-1:2], addrReg[1:0] + 2'd1};
        else          addrReg <= {addrReg[WORD_ADDR_W-1:4], addrReg[3:0] + 4'd1};
      end else if (strobe.advanceRead) begin
        if (isLegacy) addrReg <= {6'd0, addrReg[6:0] + 7'd1};
        else          addrReg <= addrReg + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitData) mem[memIdx] <= newByte;
  end

  always_comb begin
    if (strobe.driveAck)       sdaOut = 1'b0;
    else if (strobe.driveData) sdaOut = rdByte[strobe.bitSel];
    else                       sdaOut = strobe.bitIn;
  end

endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int ADDR_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOut
);

  eepStrobe_t       strobe;
  logic             started;
  logic [CYC_W-1:0] bitCyc;

  eep_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mode    (mode),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strobe  (strobe),
    .started (started),
    .bitCyc  (bitCyc)
  );

  eep_datapath #(.ADDR_BITS(ADDR_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .strobe (strobe),
    .sdaOut (sdaOut)
  );

endmodule

// File: rtl/eep_slave_checker.sv
module eep_slave_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaIn,
  input logic       sdaOut,
  input logic       started,
  input logic [5:0] bitCyc
);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclIn) && sclIn && $past(sdaIn) && !sdaIn) |=> (started && bitCyc == 6'd0));

  assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclIn) && sclIn && !$past(sdaIn) && sdaIn) |=> !started);

  assert_scl_edge_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclIn) != sclIn) |=> $stable(started));

  assert_open_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (sdaOut == sdaIn));

  assert_ack_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (started && (bitCyc == 6'd9 || bitCyc == 6'd18 || bitCyc == 6'd27)) |-> !sdaOut);

  assert_cycle_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (bitCyc <= 6'd35));

endmodule

bind eep_slave eep_slave_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaIn   (sdaIn),
  .sdaOut  (sdaOut),
  .started (started),
  .bitCyc  (bitCyc)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       sdaOut;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  eep_slave #(.ADDR_BITS(11)) u0 (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .sclIn  (scl),
    .sdaIn  (sda),
    .sdaOut (sdaOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    mode = m;
    scl  = 1'b1;
    sda  = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic startBit();
    lines(0, 1); lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic stopBit();
    lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic sendBit(input logic b);
    lines(0, b); lines(1, b); lines(0, b);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackSeen);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    lines(0, 1); lines(1, 1);
    ackSeen = sdaOut;
    lines(0, 1);
  endtask

  task automatic readByte(input logic lastOne, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      lines(0, 1); lines(1, 1);
      v[i] = sdaOut;
      lines(0, 1);
    end
    sendBit(lastOne);
  endtask

  // send a byte and check its acknowledge
  task automatic wrAck(input string req, input logic [7:0] v);
    logic a;
    sendByte(v, a);
    chk(req, $sformatf("ack for byte %0h", v), a, 0);
  endtask

  task automatic testIdle();
    doReset(2'd0);
    lines(1, 1);
    chk("R4", "idle echo high", sdaOut, 1);
    lines(0, 1); lines(0, 0);
    chk("R4", "idle echo low", sdaOut, 0);
    lines(0, 1);
  endtask

  task automatic testSameSample();
    int bad = 0;
    doReset(2'd0);
    lines(1, 1);
    lines(0, 0);          // both fall together: SCL edge only
    lines(1, 0);
    for (int p = 0; p < 9; p++) begin
      lines(0, 1); lines(1, 1);
      if (sdaOut !== 1'b1) bad++;
    end
    chk("R3", "no ack after joint change", bad, 0);
    lines(0, 1); lines(1, 1);
  endtask

  task automatic testLegacy();
    logic [7:0] v;
    doReset(2'd0);
    // R6 R7: write from address 5, five bytes, 4-byte page
    startBit();
    wrAck("R6", 8'h0A);
    wrAck("R5", 8'hA5); wrAck("R5", 8'h3C); wrAck("R5", 8'h11);
    wrAck("R5", 8'h77); wrAck("R5", 8'h99);
    stopBit();
    startBit(); wrAck("R6", 8'h00); wrAck("R6", 8'h5A); stopBit();
    startBit(); wrAck("R7", 8'hFE); wrAck("R7", 8'h42); wrAck("R7", 8'h24); stopBit();
    // sequential read from address 4
    startBit(); wrAck("R6", 8'h09);
    readByte(0, v); chk("R13", "legacy rd 4", v, 8'h77);
    readByte(0, v); chk("R7", "legacy rd 5 overwritten", v, 8'h99);
    readByte(0, v); chk("R8", "legacy rd 6", v, 8'h3C);
    readByte(1, v); chk("R8", "legacy rd 7", v, 8'h11);
    stopBit();
    startBit(); wrAck("R7", 8'hF9);
    readByte(1, v); chk("R7", "legacy page wrap 7C", v, 8'h24);
    stopBit();
    startBit(); wrAck("R8", 8'hFF);
    readByte(0, v); chk("R8", "legacy rd 7F", v, 8'h42);
    readByte(1, v); chk("R8", "legacy wrap to 00", v, 8'h5A);
    stopBit();
  endtask

  task automatic testOneByte();
    logic [7:0] v;
    logic a;
    int bad = 0;
    doReset(2'd1);
    startBit();
    wrAck("R5", 8'hA6);
    wrAck("R5", 8'hF0);
    for (int i = 0; i < 17; i++) begin
      sendByte(8'(8'h20 + i), a);
      if (a !== 1'b0) bad++;
    end
    chk("R5", "ack at 18 for each data byte", bad, 0);
    stopBit();
    startBit(); wrAck("R9", 8'hA0); wrAck("R9", 8'hF0); wrAck("R9", 8'h99); stopBit();
    startBit(); wrAck("R9", 8'hA8); wrAck("R9", 8'h00); wrAck("R9", 8'h6B); stopBit();
    // random read from 0x3FE, crossing into 0x400
    startBit(); wrAck("R12", 8'hA6); wrAck("R12", 8'hFE);
    startBit(); wrAck("R12", 8'hA7);
    readByte(0, v); chk("R13", "one rd 3FE", v, 8'h2E);
    readByte(0, v); chk("R12", "one rd 3FF", v, 8'h2F);
    readByte(1, v); chk("R12", "one rd 400", v, 8'h6B);
    stopBit();
    startBit(); wrAck("R11", 8'hA6); wrAck("R11", 8'hF0);
    startBit(); wrAck("R11", 8'hA7);
    readByte(0, v); chk("R11", "one page wrap 3F0", v, 8'h30);
    readByte(1, v); chk("R11", "one rd 3F1", v, 8'h21);
    stopBit();
    startBit(); wrAck("R9", 8'hA0); wrAck("R9", 8'hF0);
    startBit(); wrAck("R9", 8'hA1);
    readByte(1, v); chk("R9", "block 0 separate", v, 8'h99);
    stopBit();
  endtask

  task automatic testTwoByte();
    logic [7:0] v;
    doReset(2'd2);
    startBit();
    wrAck("R10", 8'hA0); wrAck("R10", 8'h07); wrAck("R5", 8'hFE);
    wrAck("R5", 8'hC1); wrAck("R5", 8'hC2); wrAck("R5", 8'hC3);
    stopBit();
    startBit(); wrAck("R10", 8'hA0); wrAck("R10", 8'h07); wrAck("R10", 8'hFE);
    startBit(); wrAck("R10", 8'hA1);
    readByte(0, v); chk("R10", "two rd 7FE", v, 8'hC1);
    readByte(1, v); chk("R10", "two rd 7FF", v, 8'hC2);
    stopBit();
    startBit(); wrAck("R11", 8'hA0); wrAck("R11", 8'h07); wrAck("R11", 8'hF0);
    startBit(); wrAck("R11", 8'hA1);
    readByte(1, v); chk("R11", "two page wrap 7F0", v, 8'hC3);
    stopBit();
  endtask

  task automatic testStop();
    int bad = 0;
    doReset(2'd1);
    startBit();
    wrAck("R2", 8'hA6);
    stopBit();
    for (int p = 0; p < 9; p++) begin
      lines(0, 1); lines(1, 1);
      if (sdaOut !== 1'b1) bad++;
    end
    chk("R2", "no ack after stop", bad, 0);
  endtask

  task automatic testStartRestart();
    logic [7:0] v;
    doReset(2'd0);
    // partial byte then a fresh start must realign the count (R1)
    startBit();
    sendBit(1); sendBit(0); sendBit(1);
    startBit();
    wrAck("R1", 8'h01);
    readByte(1, v); chk("R1", "realigned read of 00", v, 8'h5A);
    stopBit();
  endtask

  initial begin
    testIdle();
    testSameSample();
    testLegacy();
    testOneByte();
    testTwoByte();
    testStop();
    testStartRestart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule